// File: doc/BRIEF.md
# Pipelined Handshaked Four-Input Lookup Table

This block evaluates an arbitrary Boolean function of four inputs. The function is given by a static 16-bit truth table. Bit i of the table is the result for select value i, so with the table written as a 16-character string, the rightmost character is bit 0. The 16-to-1 selection is not done as one combinational read. It is cut into a chain of pipeline stages, and each stage folds the candidate bits by one or two 2:1 multiplexer levels.

Each stage has its own occupancy flag (full or empty). A stage moves its token forward only through a valid/ready exchange with its neighbours, which mimics a self-timed micropipeline in clocked logic. Several lookups can therefore be in flight at once. When the source is slow, a full token walks from the first stage to the last. When the sink is slow, a free slot opens at the last stage and passes back toward the input.

Lookups enter on a valid/ready port carrying the 4-bit select. Results leave on a valid/ready port carrying one bit. The parameter `STAGES` chooses the partitioning: four stages resolve one select bit each, and two stages resolve two select bits each. The first stage always consumes select bit 0, and each later stage consumes the next higher bits.

Top module: `hs_lut4`

## Requirements
- R1: Every accepted lookup produces exactly one result, in acceptance order, equal to bit `sel` of the truth table as it stood when the lookup was accepted.
- R2: While reset is high, every stage becomes empty. After reset, `out_valid` is 0 and `in_ready` is 1 until a lookup is accepted.
- R3: With `STAGES`=4 each stage resolves one select bit; with `STAGES`=2 each stage resolves two. Both partitionings give the same result sequence for the same lookups.
- R4: On an empty pipeline with the sink ready, a lookup accepted at clock edge k raises `out_valid` right after edge k+STAGES-1.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_bit` stays unchanged.
- R6: With the sink stalled, the block accepts exactly `STAGES` lookups and then holds `in_ready` at 0.
- R7: With the source always valid and the sink always ready, a new lookup is accepted on every clock edge, with no stall cycles.
- R8: When every stage is full, raising `out_ready` raises `in_ready` in the same cycle, because each full stage can refill while it hands its token on.
- R9: With truth table 1111_0000_1100_1010 (0xF0CA) and selects driven 0,1,...,15, the results are the table bits in ascending order. This holds for both partitionings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; empties every stage |
| cfg_bits | input | 16 | Truth table; bit i is the result for select i |
| in_valid | input | 1 | A lookup is offered |
| in_ready | output | 1 | The first stage can take a lookup this cycle |
| in_sel | input | 4 | Select value of the offered lookup |
| out_valid | output | 1 | The last stage holds a result |
| out_ready | input | 1 | The sink takes the result this cycle |
| out_bit | output | 1 | Result bit |

## Verification
Some internal faults show up at the ports within `STAGES` cycles as a wrong `out_bit`: a multiplexer level wired to the wrong select bit, or a stage that swaps its pair inputs. A stage that drops its full flag loses a result, and one that keeps the flag set duplicates one. Either fault shifts every later result, so the scoreboard reports a miscompare on the next output. Faults in the occupancy logic show up as a wrong fill count under a stalled sink, a result that changes while it is held, or stall cycles in a stream that should run at full rate.

// File: rtl/lut_pipe_pkg.sv
package lut_pipe_pkg;
    localparam int SEL_W = 4;
    localparam int TBL_W = 1 << SEL_W;

    // Token travelling between stages: surviving candidates plus the
    // select bits not yet consumed.
    typedef struct packed {
        logic [TBL_W-1:0] cand;
        logic [SEL_W-1:0] sel;
    } lut_tok_t;

    // One 2:1 level: halve the candidate vector using select bit lv,
    // then clear that select bit to mark it consumed.
    function automatic lut_tok_t fold_step(input lut_tok_t t, input int lv);
        lut_tok_t r;
        r.cand = '0;
        for (int j = 0; j < TBL_W / 2; j++) begin
            r.cand[j] = t.sel[lv] ? t.cand[2*j+1] : t.cand[2*j];
        end
        r.sel     = t.sel;
        r.sel[lv] = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/lut_fold.sv
module lut_fold
    import lut_pipe_pkg::*;
#(
    parameter int FIRST  = 0,
    parameter int LEVELS = 1
) (
    input  lut_tok_t tok_in,
    output lut_tok_t tok_out
);
    lut_tok_t lvl [LEVELS+1];

    assign lvl[0] = tok_in;

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        assign lvl[l+1] = fold_step(lvl[l], FIRST + l);
    end

    assign tok_out = lvl[LEVELS];
endmodule

// File: rtl/lut_stage.sv
module lut_stage
    import lut_pipe_pkg::*;
#(
    parameter int FIRST  = 0,
    parameter int LEVELS = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     up_valid,
    output logic     up_ready,
    input  lut_tok_t up_tok,
    output logic     dn_valid,
    input  logic     dn_ready,
    output lut_tok_t dn_tok
);
    lut_tok_t folded;
    lut_tok_t tok_q;
    logic     full_q;
    logic     take;

    lut_fold #(.FIRST(FIRST), .LEVELS(LEVELS)) u_fold (
        .tok_in  (up_tok),
        .tok_out (folded)
    );

    // Empty, or full and handing its token on in this same cycle.
    assign up_ready = !full_q || dn_ready;
    assign take     = up_valid && up_ready;

    always_ff @(posedge clk) begin
        if (rst)           full_q <= 1'b0;
        else if (take)     full_q <= 1'b1;
        else if (dn_ready) full_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (take) tok_q <= folded;
    end

    assign dn_valid = full_q;
    assign dn_tok   = tok_q;

    // R2: reset empties the stage
    a_r2_reset_empty: assert property (@(posedge clk) rst |=> !dn_valid);

    // R4: a transfer from upstream leaves this stage full
    a_r4_take_fills: assert property (@(posedge clk) disable iff (rst)
        up_valid && up_ready |=> dn_valid);

    // R5: a token blocked downstream is held unchanged
    a_r5_hold_blocked: assert property (@(posedge clk) disable iff (rst)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_tok));
endmodule

// File: rtl/hs_lut4.sv
module hs_lut4
    import lut_pipe_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TBL_W-1:0] cfg_bits,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SEL_W-1:0] in_sel,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_bit
);
    localparam int LVL   = SEL_W / STAGES;
    localparam int OCC_W = $clog2(STAGES + 1) + 1;

    lut_tok_t tok [STAGES+1];
    logic     vld [STAGES+1];
    logic     rdy [STAGES+1];

    assign tok[0].cand = cfg_bits;
    assign tok[0].sel  = in_sel;
    assign vld[0]      = in_valid;
    assign in_ready    = rdy[0];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        lut_stage #(.FIRST(s * LVL), .LEVELS(LVL)) u_stage (
            .clk      (clk),
            .rst      (rst),
            .up_valid (vld[s]),
            .up_ready (rdy[s]),
            .up_tok   (tok[s]),
            .dn_valid (vld[s+1]),
            .dn_ready (rdy[s+1]),
            .dn_tok   (tok[s+1])
        );
    end

    assign rdy[STAGES] = out_ready;
    assign out_valid   = vld[STAGES];
    assign out_bit     = tok[STAGES].cand[0];

    // Occupancy tracked from the port handshakes only, for the checks below.
    logic [OCC_W-1:0] occ_q;
    always_ff @(posedge clk) begin
        if (rst) occ_q <= '0;
        else     occ_q <= occ_q + OCC_W'(in_valid && in_ready)
                                - OCC_W'(out_valid && out_ready);
    end

    // R6: never more lookups in flight than stages
    a_r6_occ_bound: assert property (@(posedge clk) disable iff (rst)
        occ_q <= OCC_W'(STAGES));

    // R6: the input refuses only when every stage is occupied
    a_r6_refuse_when_full: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> occ_q == OCC_W'(STAGES));

    // R3: a result leaving the chain has every select bit consumed and a single candidate left
    a_r3_tree_reduced: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (tok[STAGES].sel == '0 && tok[STAGES].cand[TBL_W-1:1] == '0));
endmodule

// File: tb/tb_hs_lut4.sv
module tb_hs_lut4;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cfg;
    logic [3:0]  sel;
    logic        drv_va, drv_vb, lock;
    logic        va, vb, ra, rb, ova, ovb, ora, orb, oba, obb;

    bit q_a[$];
    bit q_b[$];
    int checks = 0;
    int fails  = 0;
    int pct_a  = 0;
    int pct_b  = 0;
    int stalls = 0;

    always #10 clk = ~clk;

    assign va = drv_va && (!lock || rb);
    assign vb = drv_vb && (!lock || ra);

    hs_lut4 #(.STAGES(4)) dut (
        .clk(clk), .rst(rst), .cfg_bits(cfg), .in_valid(va), .in_ready(ra),
        .in_sel(sel), .out_valid(ova), .out_ready(ora), .out_bit(oba));

    hs_lut4 #(.STAGES(2)) dut_two (
        .clk(clk), .rst(rst), .cfg_bits(cfg), .in_valid(vb), .in_ready(rb),
        .in_sel(sel), .out_valid(ovb), .out_ready(orb), .out_bit(obb));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: randomise sink readiness, pop and compare each delivered result.
    always begin
        @(negedge clk);
        ora = (($urandom % 100) < pct_a);
        orb = (($urandom % 100) < pct_b);
        #1;
        if (!rst && ova && ora) begin
            if (q_a.size() == 0) chk("R1 four-stage extra result", 1, 0);
            else chk("R1/R9 four-stage result", int'(oba), int'(q_a.pop_front()));
        end
        if (!rst && ovb && orb) begin
            if (q_b.size() == 0) chk("R3 two-stage extra result", 1, 0);
            else chk("R3/R9 two-stage result", int'(obb), int'(q_b.pop_front()));
        end
    end

    // Driver: offer one lookup to both instances together.
    task automatic send(input logic [3:0] s);
        @(negedge clk);
        sel = s; lock = 1'b1; drv_va = 1'b1; drv_vb = 1'b1;
        #2;
        while (!(ra && rb)) begin
            stalls++;
            @(negedge clk); #2;
        end
        q_a.push_back(cfg[s]);
        q_b.push_back(cfg[s]);
        @(posedge clk); #1;
        drv_va = 1'b0; drv_vb = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        pct_a = 100; pct_b = 100;
        while ((q_a.size() != 0 || q_b.size() != 0) && n < 100) begin
            @(negedge clk); n++;
        end
        chk("R1 four-stage results outstanding", q_a.size(), 0);
        chk("R1 two-stage results outstanding", q_b.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int na, nb, fa, fb;
        logic ha, hb;
        rst = 1'b1; cfg = 16'hF0CA; sel = '0;
        drv_va = 0; drv_vb = 0; lock = 1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #2;
        // R2: empty after reset
        chk("R2 out_valid four-stage", ova, 0);
        chk("R2 out_valid two-stage", ovb, 0);
        chk("R2 in_ready four-stage", ra, 1);
        chk("R2 in_ready two-stage", rb, 1);

        // R4: latency through an empty pipeline
        pct_a = 100; pct_b = 100;
        send(4'd5);
        fa = -1; fb = -1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #2;
            if (ova && fa < 0) fa = i;
            if (ovb && fb < 0) fb = i;
        end
        chk("R4 latency four-stage", fa, 3);
        chk("R4 latency two-stage", fb, 1);
        drain();

        // R9: counting selects on 0xF0CA, first back-to-back, then with sink stalls
        for (int i = 0; i < 16; i++) send(4'(i));
        drain();
        pct_a = 50; pct_b = 30;
        for (int i = 0; i < 16; i++) send(4'(i));
        drain();

        // R6: capacity under a stalled sink
        pct_a = 0; pct_b = 0;
        repeat (2) @(negedge clk);
        na = 0; nb = 0; lock = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            sel = 4'($urandom); drv_va = 1; drv_vb = 1;
            #2;
            if (ra) begin q_a.push_back(cfg[sel]); na++; end
            if (rb) begin q_b.push_back(cfg[sel]); nb++; end
            @(posedge clk); #1;
        end
        drv_va = 0; drv_vb = 0; lock = 1'b1;
        chk("R6 accepted four-stage", na, 4);
        chk("R6 accepted two-stage", nb, 2);
        @(negedge clk); #2;
        chk("R6 in_ready four-stage", ra, 0);
        chk("R6 in_ready two-stage", rb, 0);

        // R5: held output stays valid and unchanged
        ha = oba; hb = obb;
        repeat (5) @(negedge clk);
        #2;
        chk("R5 held valid four-stage", ova, 1);
        chk("R5 held valid two-stage", ovb, 1);
        chk("R5 held bit four-stage", int'(oba), int'(ha));
        chk("R5 held bit two-stage", int'(obb), int'(hb));
        chk("R5 held bit is oldest four-stage", int'(oba), int'(q_a[0]));

        // R8: freeing the sink reopens the input in the same cycle
        @(posedge clk);
        pct_a = 100; pct_b = 100;
        @(negedge clk); #2;
        chk("R8 in_ready four-stage", ra, 1);
        chk("R8 in_ready two-stage", rb, 1);
        drain();

        // R7: full-rate streaming
        stalls = 0;
        for (int i = 0; i < 40; i++) send(4'(i * 7));
        chk("R7 stall cycles", stalls, 0);
        drain();

        // R1/R3: random tables, selects, gaps and stalls
        for (int t = 0; t < 4; t++) begin
            cfg = 16'($urandom);
            pct_a = 70; pct_b = 40;
            for (int i = 0; i < 60; i++) begin
                repeat ($urandom % 3) @(posedge clk);
                send(4'($urandom));
            end
            drain();
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule